// File: doc/BRIEF.md
# Mode Code Descriptor Legality Controller

This block holds the per-command control logic of a MIL-STD-1553 remote terminal for mode codes that carry a data word. Each decoded command arrives with a 16-bit descriptor word and several attributes: whether it was broadcast, its direction (transmit or receive), and whether the command was valid. The block uses the descriptor's three illegalization controls to decide whether the command is legal. From that decision it produces the response flags: message error, broadcast, status suppression and data suppression.

The block also raises three interrupt requests. Illegal-broadcast and illegal-command requests are gated by separate enable inputs. The subaddress event request fires on every transaction, or when the buffer index runs out, according to two descriptor bits. The block keeps a 7-bit message index in the low descriptor bits that counts down and stops at zero. It writes the updated descriptor back, and it builds the stored message status word, which includes the subsystem failure input.

One command is accepted per clock through a valid/ready handshake. All results are registered, so they appear one cycle after acceptance.

Top module: `mcd_legality_ctrl`

## Requirements
- R1: After reset, all response outputs and interrupt pulses are 0 and `cmd_ready` is 1. An accepted command (`cmd_valid` and `cmd_ready` both 1) produces `rsp_valid`=1 for exactly the next cycle, and its results are presented in that cycle.
- R2: A valid broadcast command whose descriptor bit 11 is 1 is illegal. It sets `rsp_me`=1 and `rsp_bcast`=1. Every valid broadcast command, legal or illegal, sets `rsp_no_status`=1.
- R3: A valid non-broadcast transmit command (`cmd_xmit`=1) whose descriptor bit 10 is 1 is illegal. It gives `rsp_me`=1 and `rsp_no_data`=1.
- R4: A valid non-broadcast receive command (`cmd_xmit`=0) whose descriptor bit 9 is 1 is illegal. It gives `rsp_me`=1 and `rsp_no_data`=0.
- R5: `irq_ill_bcast` pulses for an illegal broadcast only when `en_ill_bcast`=1. `irq_ill_cmd` pulses for an illegal non-broadcast command only when `en_ill_cmd`=1. `rsp_me` is 1 whatever the enables are.
- R6: A command is stored when it is valid and legal. A stored command whose descriptor bit 8 is 1 pulses `irq_sa_event`.
- R7: A stored command with a nonzero index in descriptor bits 6..0 writes that index back decremented by one.
- R8: The index is written back unchanged when the command is invalid, when it is illegal, or when the index is already 0.
- R9: A stored command with descriptor bit 7 = 1 and an index of 1 pulses `irq_sa_event`, because the index goes from 1 to 0.
- R10: When bit 8 and the 1-to-0 condition of bit 7 both apply, `irq_sa_event` is high for one cycle only.
- R11: Descriptor bits 15..7, including the reserved bit 12, are written back unchanged in `rsp_desc`.
- R12: In `rsp_msg_sts`, bit 15 is `ssf_in` as sampled at acceptance, bit 14 is 1 for a valid broadcast, bit 13 equals `rsp_me`, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_desc | input | 16 | Descriptor word for the mode code |
| cmd_bcast | input | 1 | Command was broadcast |
| cmd_xmit | input | 1 | 1 = transmit, 0 = receive |
| cmd_ok | input | 1 | Command passed validity checks |
| ssf_in | input | 1 | Subsystem failure input |
| en_ill_bcast | input | 1 | Enable for the illegal-broadcast interrupt |
| en_ill_cmd | input | 1 | Enable for the illegal-command interrupt |
| rsp_valid | output | 1 | Results valid this cycle |
| rsp_me | output | 1 | Message error flag |
| rsp_bcast | output | 1 | Broadcast flag |
| rsp_no_status | output | 1 | Do not transmit the status word |
| rsp_no_data | output | 1 | Do not transmit the data word |
| rsp_desc | output | 16 | Updated descriptor to write back |
| rsp_msg_sts | output | 16 | Stored message status word |
| irq_ill_bcast | output | 1 | Illegal-broadcast interrupt pulse |
| irq_ill_cmd | output | 1 | Illegal-command interrupt pulse |
| irq_sa_event | output | 1 | Subaddress event interrupt pulse |

## Verification
Two functions can fall in the same cycle: the per-transaction event from bit 8 and the buffers-full event from bit 7, when the index goes from 1 to 0. The bench provokes this with a descriptor that has both bits set and an index of 1. It checks that `irq_sa_event` is high in the response cycle and low in the cycle after, and that the index lands on 0. A second overlap is an illegal command together with a nonzero index. That case is judged by the index coming back unchanged while `rsp_me` is set.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int DESC_W   = 16;
  localparam int IDX_W    = 7;
  localparam int B_ILL_BC = 11;
  localparam int B_ILL_TX = 10;
  localparam int B_ILL_RX = 9;
  localparam int B_EV_ALL = 8;
  localparam int B_EV_ZERO = 7;
  localparam int S_SSF    = 15;
  localparam int S_BCAST  = 14;
  localparam int S_ME     = 13;

  // next index value: count down by one when stored, floor at zero
  function automatic logic [IDX_W-1:0] f_idx_next(input logic [IDX_W-1:0] idx,
                                                  input logic store);
    logic [IDX_W-1:0] one;
    one = {{(IDX_W-1){1'b0}}, 1'b1};
    if (store && (idx != '0)) return idx - one;
    return idx;
  endfunction

  // index reaches zero on this message
  function automatic logic f_hits_zero(input logic [IDX_W-1:0] idx,
                                       input logic store);
    return store && (idx == {{(IDX_W-1){1'b0}}, 1'b1});
  endfunction

  // which illegalization control applies to this command
  function automatic logic f_illegal(input logic ill_bc, input logic ill_tx,
                                     input logic ill_rx, input logic bcast,
                                     input logic xmit, input logic ok);
    if (!ok)   return 1'b0;
    if (bcast) return ill_bc;
    return xmit ? ill_tx : ill_rx;
  endfunction
endpackage

// File: rtl/mcd_legality.sv
module mcd_legality
  import mcd_pkg::*;
(
  input  logic ill_bc,
  input  logic ill_tx,
  input  logic ill_rx,
  input  logic bcast,
  input  logic xmit,
  input  logic ok,
  output logic illegal,
  output logic ill_bcast,
  output logic ill_cmd,
  output logic no_data
);
  always_comb begin
    illegal   = f_illegal(ill_bc, ill_tx, ill_rx, bcast, xmit, ok);
    ill_bcast = illegal && bcast;
    ill_cmd   = illegal && !bcast;
    no_data   = ill_cmd && xmit;
  end
endmodule

// File: rtl/mcd_index.sv
module mcd_index
  import mcd_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0] idx_cur,
  input  logic          store,
  output logic [IW-1:0] idx_next,
  output logic          hit_zero
);
  always_comb begin
    idx_next = f_idx_next(idx_cur, store);
    hit_zero = f_hits_zero(idx_cur, store);
  end
endmodule

// File: rtl/mcd_irq.sv
module mcd_irq (
  input  logic store,
  input  logic ev_all_en,
  input  logic ev_zero_en,
  input  logic hit_zero,
  input  logic ill_bcast,
  input  logic ill_cmd,
  input  logic en_bcast,
  input  logic en_cmd,
  output logic irq_bcast,
  output logic irq_cmd,
  output logic irq_sa
);
  always_comb begin
    irq_bcast = ill_bcast && en_bcast;
    irq_cmd   = ill_cmd && en_cmd;
    // two triggers merge into one request
    irq_sa    = store && (ev_all_en || (ev_zero_en && hit_zero));
  end
endmodule

// File: rtl/mcd_legality_ctrl.sv
module mcd_legality_ctrl
  import mcd_pkg::*;
#(
  parameter int DW = DESC_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [DW-1:0] cmd_desc,
  input  logic          cmd_bcast,
  input  logic          cmd_xmit,
  input  logic          cmd_ok,
  input  logic          ssf_in,
  input  logic          en_ill_bcast,
  input  logic          en_ill_cmd,
  output logic          rsp_valid,
  output logic          rsp_me,
  output logic          rsp_bcast,
  output logic          rsp_no_status,
  output logic          rsp_no_data,
  output logic [DW-1:0] rsp_desc,
  output logic [DW-1:0] rsp_msg_sts,
  output logic          irq_ill_bcast,
  output logic          irq_ill_cmd,
  output logic          irq_sa_event
);
  localparam int UPW = DW - IW;

  // named internal events
  logic          acc;
  logic          w_illegal, w_ill_bc, w_ill_cmd, w_no_data;
  logic          w_store, w_hit_zero;
  logic [IW-1:0] w_idx_next;
  logic          w_irq_b, w_irq_c, w_irq_sa;
  logic          w_vbcast;
  logic [DW-1:0] w_sts;

  assign acc      = cmd_valid && cmd_ready;
  assign w_store  = cmd_ok && !w_illegal;
  assign w_vbcast = cmd_ok && cmd_bcast;

  mcd_legality u_leg (
    .ill_bc   (cmd_desc[B_ILL_BC]),
    .ill_tx   (cmd_desc[B_ILL_TX]),
    .ill_rx   (cmd_desc[B_ILL_RX]),
    .bcast    (cmd_bcast),
    .xmit     (cmd_xmit),
    .ok       (cmd_ok),
    .illegal  (w_illegal),
    .ill_bcast(w_ill_bc),
    .ill_cmd  (w_ill_cmd),
    .no_data  (w_no_data)
  );

  mcd_index #(.IW(IW)) u_idx (
    .idx_cur (cmd_desc[IW-1:0]),
    .store   (w_store),
    .idx_next(w_idx_next),
    .hit_zero(w_hit_zero)
  );

  mcd_irq u_irq (
    .store     (w_store),
    .ev_all_en (cmd_desc[B_EV_ALL]),
    .ev_zero_en(cmd_desc[B_EV_ZERO]),
    .hit_zero  (w_hit_zero),
    .ill_bcast (w_ill_bc),
    .ill_cmd   (w_ill_cmd),
    .en_bcast  (en_ill_bcast),
    .en_cmd    (en_ill_cmd),
    .irq_bcast (w_irq_b),
    .irq_cmd   (w_irq_c),
    .irq_sa    (w_irq_sa)
  );

  always_comb begin
    w_sts          = '0;
    w_sts[S_SSF]   = ssf_in;
    w_sts[S_BCAST] = w_vbcast;
    w_sts[S_ME]    = w_illegal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready     <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_me        <= 1'b0;
      rsp_bcast     <= 1'b0;
      rsp_no_status <= 1'b0;
      rsp_no_data   <= 1'b0;
      rsp_desc      <= '0;
      rsp_msg_sts   <= '0;
      irq_ill_bcast <= 1'b0;
      irq_ill_cmd   <= 1'b0;
      irq_sa_event  <= 1'b0;
    end else begin
      cmd_ready     <= 1'b1;
      rsp_valid     <= acc;
      rsp_me        <= acc && w_illegal;
      rsp_bcast     <= acc && w_vbcast;
      rsp_no_status <= acc && w_vbcast;
      rsp_no_data   <= acc && w_no_data;
      irq_ill_bcast <= acc && w_irq_b;
      irq_ill_cmd   <= acc && w_irq_c;
      irq_sa_event  <= acc && w_irq_sa;
      if (acc) begin
        rsp_desc    <= {cmd_desc[DW-1:IW], w_idx_next};
        rsp_msg_sts <= w_sts;
      end
    end
  end

  // assertions
  AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);  // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid && !irq_sa_event && !irq_ill_cmd && !irq_ill_bcast);  // R1
  AST_BCAST_ME: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ill_bcast |-> rsp_me && rsp_bcast && rsp_no_status);  // R2
  AST_NODATA_ME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_no_data |-> rsp_me && !rsp_bcast);  // R3
  AST_CMD_IRQ_ME: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ill_cmd |-> rsp_me);  // R5
  AST_IDX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_desc[IW-1:0] == '0) |=> rsp_desc[IW-1:0] == '0);  // R8
  AST_ILLEGAL_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !w_store |=> rsp_desc == $past(cmd_desc));  // R8
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_desc[DW-1:IW] == $past(cmd_desc[DW-1:IW]));  // R11
  AST_ME_IN_STS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_msg_sts[S_ME] == rsp_me);  // R12
  AST_SA_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sa_event |-> rsp_valid && !rsp_me);  // R6
endmodule

// File: tb/mcd_legality_ctrl_tb.sv
module mcd_legality_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_desc = '0;
  logic        cmd_bcast = 1'b0, cmd_xmit = 1'b0, cmd_ok = 1'b0, ssf_in = 1'b0;
  logic        en_ill_bcast = 1'b0, en_ill_cmd = 1'b0;
  logic        rsp_valid, rsp_me, rsp_bcast, rsp_no_status, rsp_no_data;
  logic [15:0] rsp_desc, rsp_msg_sts;
  logic        irq_ill_bcast, irq_ill_cmd, irq_sa_event;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcd_legality_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_desc(cmd_desc), .cmd_bcast(cmd_bcast), .cmd_xmit(cmd_xmit),
    .cmd_ok(cmd_ok), .ssf_in(ssf_in), .en_ill_bcast(en_ill_bcast),
    .en_ill_cmd(en_ill_cmd), .rsp_valid(rsp_valid), .rsp_me(rsp_me),
    .rsp_bcast(rsp_bcast), .rsp_no_status(rsp_no_status),
    .rsp_no_data(rsp_no_data), .rsp_desc(rsp_desc), .rsp_msg_sts(rsp_msg_sts),
    .irq_ill_bcast(irq_ill_bcast), .irq_ill_cmd(irq_ill_cmd),
    .irq_sa_event(irq_sa_event)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // present one command at a falling edge; results checked at the next falling edge
  task automatic send(input logic [15:0] d, input logic b, input logic x,
                      input logic ok, input logic ssf,
                      input logic eb, input logic ec);
    cmd_desc = d; cmd_bcast = b; cmd_xmit = x; cmd_ok = ok; ssf_in = ssf;
    en_ill_bcast = eb; en_ill_cmd = ec; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R1", "irqs", {13'd0, irq_ill_bcast, irq_ill_cmd, irq_sa_event}, 16'd0);
    chk("R1", "cmd_ready", {15'd0, cmd_ready}, 16'd1);
  endtask

  task automatic t_legal_rx;
    send(16'h0005, 0, 0, 1, 0, 1, 1);
    chk("R1", "rsp_valid", {15'd0, rsp_valid}, 16'd1);
    chk("R7", "desc", rsp_desc, 16'h0004);
    chk("R7", "me", {15'd0, rsp_me}, 16'd0);
    chk("R6", "sa idle", {15'd0, irq_sa_event}, 16'd0);
    @(negedge clk);
    chk("R1", "valid drops", {15'd0, rsp_valid}, 16'd0);
  endtask

  task automatic t_each_event;
    send(16'h0103, 0, 1, 1, 0, 0, 0);
    chk("R6", "sa every", {15'd0, irq_sa_event}, 16'd1);
    chk("R7", "desc", rsp_desc, 16'h0102);
  endtask

  task automatic t_zero_event;
    send(16'h0081, 0, 0, 1, 0, 0, 0);
    chk("R9", "sa at zero", {15'd0, irq_sa_event}, 16'd1);
    chk("R9", "desc", rsp_desc, 16'h0080);
    send(16'h0080, 0, 0, 1, 0, 0, 0);
    chk("R8", "floor", rsp_desc, 16'h0080);
    chk("R9", "no sa at floor", {15'd0, irq_sa_event}, 16'd0);
  endtask

  task automatic t_both_events;
    send(16'h0181, 0, 0, 1, 0, 0, 0);
    chk("R10", "sa pulse", {15'd0, irq_sa_event}, 16'd1);
    chk("R10", "desc", rsp_desc, 16'h0180);
    @(negedge clk);
    chk("R10", "sa single", {15'd0, irq_sa_event}, 16'd0);
  endtask

  task automatic t_invalid;
    send(16'h0703, 0, 1, 0, 0, 1, 1);
    chk("R8", "invalid keeps", rsp_desc, 16'h0703);
    chk("R8", "invalid no me", {15'd0, rsp_me}, 16'd0);
    chk("R8", "invalid no irq", {13'd0, irq_ill_bcast, irq_ill_cmd, irq_sa_event}, 16'd0);
  endtask

  task automatic t_bcast;
    send(16'h0902, 1, 0, 1, 1, 1, 0);
    chk("R2", "me", {15'd0, rsp_me}, 16'd1);
    chk("R2", "bcast/nostatus", {14'd0, rsp_bcast, rsp_no_status}, 16'd3);
    chk("R5", "irq bcast", {15'd0, irq_ill_bcast}, 16'd1);
    chk("R12", "msg sts", rsp_msg_sts, 16'hE000);
    chk("R8", "illegal keeps", rsp_desc, 16'h0902);
    chk("R6", "no sa on illegal", {15'd0, irq_sa_event}, 16'd0);
    send(16'h0802, 1, 0, 1, 0, 0, 1);
    chk("R5", "bcast masked", {14'd0, irq_ill_bcast, irq_ill_cmd}, 16'd0);
    chk("R5", "me unmasked", {15'd0, rsp_me}, 16'd1);
    send(16'h0003, 1, 0, 1, 0, 1, 1);
    chk("R2", "legal bcast", {13'd0, rsp_me, rsp_bcast, rsp_no_status}, 16'd3);
    chk("R12", "msg sts", rsp_msg_sts, 16'h4000);
    chk("R7", "desc", rsp_desc, 16'h0002);
  endtask

  task automatic t_xmit;
    send(16'h1407, 0, 1, 1, 0, 0, 1);
    chk("R3", "me/nodata", {14'd0, rsp_me, rsp_no_data}, 16'd3);
    chk("R5", "irq cmd", {15'd0, irq_ill_cmd}, 16'd1);
    chk("R11", "reserved kept", rsp_desc, 16'h1407);
    chk("R12", "msg sts", rsp_msg_sts, 16'h2000);
  endtask

  task automatic t_rx;
    send(16'h0207, 0, 0, 1, 0, 1, 0);
    chk("R4", "me/nodata", {14'd0, rsp_me, rsp_no_data}, 16'd2);
    chk("R5", "cmd masked", {15'd0, irq_ill_cmd}, 16'd0);
    send(16'h0207, 0, 1, 1, 0, 0, 0);
    chk("R4", "tx not gated by rx bit", {15'd0, rsp_me}, 16'd0);
    chk("R7", "desc", rsp_desc, 16'h0206);
  endtask

  task automatic t_upper;
    send(16'hF47A, 0, 0, 1, 0, 0, 0);
    chk("R11", "upper kept", rsp_desc, 16'hF479);
    send(16'h007F, 0, 0, 1, 0, 0, 0);
    chk("R7", "max idx", rsp_desc, 16'h007E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legal_rx();
    t_each_event();
    t_zero_event();
    t_both_events();
    t_invalid();
    t_bcast();
    t_xmit();
    t_rx();
    t_upper();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule